// File: doc/BRIEF.md
# Dual-Output Interrupt Controller Registers

This block is the register and aggregation side of an interrupt controller with 51 sources. A 32-bit register bus with a combinational read path reaches its state. Each 51-bit logical register appears as two 32-bit words: a low word for sources 0 to 31 and a high word for sources 32 to 50. The block keeps the pending, steering, enable and polarity state. It reduces that state to two registered request lines: a normal interrupt and a fast interrupt.

The per-source trigger detector is a separate block. The detector reads the sensitivity, both-edge and polarity configuration from the `cfg_*_o` outputs. It returns one bit per source on `src_i`. For level-sensitive sources that bit is the qualified level. For edge-sensitive sources it is a one-cycle detected-edge pulse. Level pending bits track `src_i` one clock later. Edge pending bits stay set until software clears them.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Register decoding starts at byte address 0x80. Any read below 0x80 returns zero, and any write below 0x80 changes no state.
- R2: Address bit 2 set selects the high word (sources 32..50). High-word reads return only bits 18:0, and high-word writes use only wdata bits 18:0.
- R3: After reset, pending, select and enable are all zero and both outputs are low. Sensitivity reads low 0xFFF8FFFF and high 0x1F07 (bit set = level). Both-edge reads low 0x00070000 and high 0xF8. Polarity reads low 0xFFF8FFFF and high 0x5F07.
- R4: irq_o rises one clock after any bit of pending & enable & ~select is set, and fiq_o does the same for pending & enable & select. The words at 0x80 (normal) and 0x88 (fast) read those masked vectors.
- R5: Writing to 0xA0 (low) or 0xA4 (high) sets the enable bits written as one. Writing to 0xA8 or 0xAC clears them. The enable mask reads back at 0xA0 and 0xA4.
- R6: Level sources (sensitivity 1) show src_i in their pending bit one clock later. Writing ones to 0xD8 or 0xDC clears pending bits of edge sources only. The words at 0xE0 and 0xE4 read pending & ~sensitivity, and the raw pending words are at 0x90 and 0x94.
- R7: A write to select (0x98 low, 0x9C high) replaces the addressed word and leaves the other word unchanged. A select bit of 1 steers that source to fiq_o.
- R8: The polarity register (0xD0 and 0xD4) is writable only at high-word bits 18:15 (sources 47..50). Writes to the low word, and to the other high-word bits, are ignored.
- R9: The clear-only words (0xA8, 0xB8, 0xD8 and their high words), the software-interrupt words 0xB0 and 0xB4, and unmapped offsets (0xE8 and above) all read zero. Writes to 0x80, 0x88, 0x90, 0xB0, 0xC0, 0xC8 and 0xE0 have no effect.
- R10: An edge pulse on src_i sets its pending bit, and the bit stays set until it is cleared. If a pulse and a clear of the same bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte address of the bus access |
| we_i | input | 1 | Write strobe, one access per cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| src_i | input | 51 | Per-source level or edge pulse from the trigger detector |
| cfg_sense_o | output | 51 | Sensitivity per source, 1 = level |
| cfg_dual_o | output | 51 | Both-edge enable per source |
| cfg_event_o | output | 51 | Polarity per source, 1 = high or rising |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The bench holds a level source and checks it on each output: first unmasked, then masked off, then moved between the two outputs through select. Only the right line may rise, and only after the one-clock register stage. Edge sources, including one in the high word, are pulsed and then checked over several idle cycles. This shows a held pending bit apart from a tracked one. A clear that sets all ones is used to show that only edge bits are removed. A pulse placed in the same cycle as its clear shows whether the set or the clear wins. Writes of all ones to the read-only words, the software words, the polarity low word and addresses below the window must leave every readable word unchanged. This separates correct decoding from aliasing.

// File: rtl/dual_irq_pkg.sv
package dual_irq_pkg;

  typedef enum logic [3:0] {
    K_NSTAT     = 4'd0,
    K_FSTAT     = 4'd1,
    K_RAW       = 4'd2,
    K_SEL       = 4'd3,
    K_EN_SET    = 4'd4,
    K_EN_CLR    = 4'd5,
    K_SW_SET    = 4'd6,
    K_SW_CLR    = 4'd7,
    K_SENSE     = 4'd8,
    K_DUAL      = 4'd9,
    K_EVT       = 4'd10,
    K_EDGE_CLR  = 4'd11,
    K_EDGE_STAT = 4'd12,
    K_NONE      = 4'd15
  } reg_key_e;

  typedef struct packed {
    logic     in_win;
    logic     hi;
    reg_key_e key;
  } acc_t;

  localparam logic [63:0] SENSE_RST64 = 64'h0000_1F07_FFF8_FFFF;
  localparam logic [63:0] DUAL_RST64  = 64'h0000_00F8_0007_0000;
  localparam logic [63:0] EVT_RST64   = 64'h0000_5F07_FFF8_FFFF;

endpackage

// File: rtl/dual_irq_decode.sv
module dual_irq_decode
  import dual_irq_pkg::*;
#(
  parameter int          AW   = 12,
  parameter logic [11:0] BASE = 12'h080
) (
  input  logic [AW-1:0] addr_i,
  output acc_t          acc_o
);
  localparam int IDX_W = AW - 3;

  logic [AW-1:0]    rel;
  logic [IDX_W-1:0] idx;
  logic             unused_lsb;

  assign rel        = addr_i - AW'(BASE);
  assign idx        = rel[AW-1:3];
  assign unused_lsb = ^rel[1:0];

  always_comb begin
    acc_o.in_win = (addr_i >= AW'(BASE));
    acc_o.hi     = rel[2];
    if (acc_o.in_win && (idx <= IDX_W'(12))) acc_o.key = reg_key_e'(idx[3:0]);
    else                                     acc_o.key = K_NONE;
  end

endmodule

// File: rtl/dual_irq_pending.sv
module dual_irq_pending #(
  parameter int               NSRC  = 51,
  parameter logic [NSRC-1:0]  SENSE = '1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] raw_o
);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (SENSE[i]) begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i[i];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) raw_o[i] <= 1'b0;
        else         raw_o[i] <= src_i[i];
      end
    end else begin : g_edge
      // new pulse beats a same-cycle clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) raw_o[i] <= 1'b0;
        else         raw_o[i] <= src_i[i] | (raw_o[i] & ~clr_i[i]);
      end
    end
  end

  // R6: level pending mirrors the source one clock later, clear or not
  p_level_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_o & SENSE) == ($past(src_i) & SENSE)));

  // R10: an edge pulse always lands in pending
  p_edge_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_o & $past(src_i) & ~SENSE) == ($past(src_i) & ~SENSE)));

  // R10: without pulse or clear an edge bit holds
  p_edge_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i | src_i) == '0) |=> ((raw_o & ~SENSE) == ($past(raw_o) & ~SENSE)));

endmodule

// File: rtl/dual_irq_combine.sv
module dual_irq_combine #(
  parameter int NSRC = 51
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [NSRC-1:0] sel_i,
  output logic [NSRC-1:0] nstat_o,
  output logic [NSRC-1:0] fstat_o,
  output logic            irq_o,
  output logic            fiq_o
);
  logic [NSRC-1:0] live;

  assign live    = raw_i & en_i;
  assign nstat_o = live & ~sel_i;
  assign fstat_o = live & sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |nstat_o;
      fiq_o <= |fstat_o;
    end
  end

  // R4: an output line needs an enabled pending source the cycle before
  p_out_needs_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || fiq_o) |-> $past(|(raw_i & en_i)));

  // R7: an unsteered source alone never drives the fast line
  p_fast_needs_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(|sel_i));

endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dual_irq_pkg::*;
#(
  parameter int              NSRC      = 51,
  parameter int              DW        = 32,
  parameter int              AW        = 12,
  parameter logic [11:0]     BASE      = 12'h080,
  parameter int              EVT_LO    = 47,
  parameter int              EVT_HI    = 50,
  parameter logic [NSRC-1:0] SENSE_RST = SENSE_RST64[NSRC-1:0],
  parameter logic [NSRC-1:0] DUAL_RST  = DUAL_RST64[NSRC-1:0],
  parameter logic [NSRC-1:0] EVT_RST   = EVT_RST64[NSRC-1:0]
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic            we_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [NSRC-1:0] src_i,
  output logic [NSRC-1:0] cfg_sense_o,
  output logic [NSRC-1:0] cfg_dual_o,
  output logic [NSRC-1:0] cfg_event_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int              HI_W     = NSRC - DW;
  localparam int              EVT_N    = EVT_HI - EVT_LO + 1;
  localparam logic [NSRC-1:0] EVT_MASK = ({NSRC{1'b1}} >> (NSRC - EVT_N)) << EVT_LO;
  localparam logic [NSRC-1:0] LO_MASK  = {{HI_W{1'b0}}, {DW{1'b1}}};

  acc_t            acc;
  logic [NSRC-1:0] wvec, hmask;
  logic [NSRC-1:0] sel_q, en_q, evt_q;
  logic [NSRC-1:0] raw, nstat, fstat, edge_clr, view;
  logic            wr_sel, wr_en_set, wr_en_clr, wr_evt, wr_edge_clr;

  dual_irq_decode #(.AW(AW), .BASE(BASE)) u_decode (
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  // place write data into the addressed word
  assign wvec  = acc.hi ? {wdata_i[HI_W-1:0], {DW{1'b0}}} : {{HI_W{1'b0}}, wdata_i};
  assign hmask = acc.hi ? ~LO_MASK : LO_MASK;

  assign wr_sel      = we_i && (acc.key == K_SEL);
  assign wr_en_set   = we_i && (acc.key == K_EN_SET);
  assign wr_en_clr   = we_i && (acc.key == K_EN_CLR);
  assign wr_evt      = we_i && (acc.key == K_EVT) && acc.hi;
  assign wr_edge_clr = we_i && (acc.key == K_EDGE_CLR);

  assign edge_clr = wr_edge_clr ? (wvec & ~SENSE_RST) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      en_q  <= '0;
      evt_q <= EVT_RST;
    end else begin
      if (wr_sel)    sel_q <= (sel_q & ~hmask) | wvec;
      if (wr_en_set) en_q  <= en_q | wvec;
      if (wr_en_clr) en_q  <= en_q & ~wvec;
      if (wr_evt)    evt_q <= (evt_q & ~EVT_MASK) | (wvec & EVT_MASK);
    end
  end

  dual_irq_pending #(.NSRC(NSRC), .SENSE(SENSE_RST)) u_pending (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .clr_i  (edge_clr),
    .raw_o  (raw)
  );

  dual_irq_combine #(.NSRC(NSRC)) u_combine (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw),
    .en_i    (en_q),
    .sel_i   (sel_q),
    .nstat_o (nstat),
    .fstat_o (fstat),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  assign cfg_sense_o = SENSE_RST;
  assign cfg_dual_o  = DUAL_RST;
  assign cfg_event_o = evt_q;

  always_comb begin
    unique case (acc.key)
      K_NSTAT:     view = nstat;
      K_FSTAT:     view = fstat;
      K_RAW:       view = raw;
      K_SEL:       view = sel_q;
      K_EN_SET:    view = en_q;
      K_SENSE:     view = SENSE_RST;
      K_DUAL:      view = DUAL_RST;
      K_EVT:       view = evt_q;
      K_EDGE_STAT: view = raw & ~SENSE_RST;
      default:     view = '0;
    endcase
  end

  assign rdata_o = acc.hi ? {{(2*DW-NSRC){1'b0}}, view[NSRC-1:DW]} : view[DW-1:0];

  // R1: nothing below the window reads back
  p_below_window_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < AW'(BASE)) |-> (rdata_o == '0));

  // R2: high-word reads never carry bits beyond the source count
  p_hi_read_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc.hi |-> (rdata_o[DW-1:HI_W] == '0));

  // R5: bits written to the clear word are gone next cycle
  p_en_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_clr |=> ((en_q & $past(wvec)) == '0));

  // R7: a high-word select write keeps the low word
  p_sel_keep_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel && acc.hi) |=> (sel_q[DW-1:0] == $past(sel_q[DW-1:0])));

  // R8: low-word polarity writes change nothing
  p_evt_lo_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (acc.key == K_EVT) && !acc.hi) |=> $stable(evt_q));

endmodule

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb_top;
  localparam int NSRC = 51;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [11:0]     addr = '0;
  logic            we = 1'b0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NSRC-1:0] src = '0;
  logic [NSRC-1:0] cfg_sense, cfg_dual, cfg_event;
  logic            irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_irq_ctrl dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .we_i        (we),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .src_i       (src),
    .cfg_sense_o (cfg_sense),
    .cfg_dual_o  (cfg_dual),
    .cfg_event_o (cfg_event),
    .irq_o       (irq),
    .fiq_o       (fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    src[idx] = 1'b1;
    @(negedge clk);
    src[idx] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R3 irq", {31'b0, irq}, 0);
    chk("R3 fiq", {31'b0, fiq}, 0);
    rd_chk("R3 raw lo",   12'h090, 32'h0);
    rd_chk("R3 sel hi",   12'h09C, 32'h0);
    rd_chk("R3 en lo",    12'h0A0, 32'h0);
    rd_chk("R3 sense lo", 12'h0C0, 32'hFFF8_FFFF);
    rd_chk("R3 sense hi", 12'h0C4, 32'h0000_1F07);
    rd_chk("R3 dual lo",  12'h0C8, 32'h0007_0000);
    rd_chk("R3 dual hi",  12'h0CC, 32'h0000_00F8);
    rd_chk("R3 evt lo",   12'h0D0, 32'hFFF8_FFFF);
    rd_chk("R3 evt hi",   12'h0D4, 32'h0000_5F07);
  endtask

  task automatic t_window;
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h07C, 32'hFFFF_FFFF);
    rd_chk("R1 no alias en lo", 12'h0A0, 32'h0);
    rd_chk("R1 no alias en hi", 12'h0A4, 32'h0);
    rd_chk("R1 no alias sel",   12'h098, 32'h0);
    wr(12'h0A0, 32'h0000_0005);
    rd_chk("R1 read 0x20 zero", 12'h020, 32'h0);
    rd_chk("R1 read 0x7C zero", 12'h07C, 32'h0);
    wr(12'h0A8, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable;
    wr(12'h0A0, 32'h0000_00F0);
    wr(12'h0A0, 32'h0000_000F);
    rd_chk("R5 set ors", 12'h0A0, 32'h0000_00FF);
    wr(12'h0A8, 32'h0000_0033);
    rd_chk("R5 clear ones", 12'h0A0, 32'h0000_00CC);
    wr(12'h0A4, 32'hFFFF_FFFF);
    rd_chk("R2 en hi masked", 12'h0A4, 32'h0007_FFFF);
    rd_chk("R2 lo kept", 12'h0A0, 32'h0000_00CC);
    wr(12'h0AC, 32'h0000_0001);
    rd_chk("R5 clear hi", 12'h0A4, 32'h0007_FFFE);
    wr(12'h0A8, 32'hFFFF_FFFF);
    wr(12'h0AC, 32'hFFFF_FFFF);
    rd_chk("R5 all clear", 12'h0A4, 32'h0);
  endtask

  task automatic t_level_route;
    wr(12'h0A0, 32'h0000_0008);
    src[3] = 1'b1;
    idle(2);
    chk("R4 irq up", {31'b0, irq}, 1);
    chk("R4 fiq low", {31'b0, fiq}, 0);
    rd_chk("R4 nstat", 12'h080, 32'h8);
    rd_chk("R4 fstat", 12'h088, 32'h0);
    wr(12'h098, 32'h0000_0008);
    idle(1);
    chk("R7 fiq up", {31'b0, fiq}, 1);
    chk("R7 irq down", {31'b0, irq}, 0);
    rd_chk("R7 fstat", 12'h088, 32'h8);
    rd_chk("R7 nstat", 12'h080, 32'h0);
    src[3] = 1'b0;
    idle(2);
    chk("R6 level drop fiq", {31'b0, fiq}, 0);
    rd_chk("R6 level raw gone", 12'h090, 32'h0);
    wr(12'h098, 32'h0);
    src[4] = 1'b1;
    idle(2);
    rd_chk("R4 masked raw seen", 12'h090, 32'h10);
    chk("R4 masked no irq", {31'b0, irq}, 0);
    src[4] = 1'b0;
    wr(12'h0A8, 32'hFFFF_FFFF);
    idle(1);
  endtask

  task automatic t_edge;
    pulse(17);
    idle(3);
    rd_chk("R10 edge held", 12'h090, 32'h0002_0000);
    rd_chk("R6 edge stat", 12'h0E0, 32'h0002_0000);
    src[3] = 1'b1;
    idle(1);
    wr(12'h0D8, 32'hFFFF_FFFF);
    rd_chk("R6 clear edge only", 12'h090, 32'h0000_0008);
    rd_chk("R6 edge stat empty", 12'h0E0, 32'h0);
    src[3] = 1'b0;
    pulse(48);
    rd_chk("R2 hi raw", 12'h094, 32'h0001_0000);
    rd_chk("R6 hi edge stat", 12'h0E4, 32'h0001_0000);
    wr(12'h0A4, 32'h0001_0000);
    idle(1);
    chk("R4 edge irq", {31'b0, irq}, 1);
    idle(4);
    chk("R10 edge irq holds", {31'b0, irq}, 1);
    wr(12'h0DC, 32'h0001_0000);
    idle(1);
    chk("R6 cleared irq", {31'b0, irq}, 0);
    rd_chk("R6 hi raw clear", 12'h094, 32'h0);
    wr(12'h0AC, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    addr = 12'h0D8; wdata = 32'h0002_0000; we = 1'b1; src[17] = 1'b1;
    @(negedge clk);
    we = 1'b0; src[17] = 1'b0;
    rd_chk("R10 set beats clear", 12'h090, 32'h0002_0000);
    wr(12'h0D8, 32'h0002_0000);
    rd_chk("R10 later clear", 12'h090, 32'h0);
  endtask

  task automatic t_select;
    wr(12'h098, 32'h0000_00FF);
    wr(12'h09C, 32'hFFFF_FFFF);
    rd_chk("R2 sel hi masked", 12'h09C, 32'h0007_FFFF);
    rd_chk("R7 lo kept", 12'h098, 32'h0000_00FF);
    wr(12'h098, 32'h0000_000F);
    rd_chk("R7 lo replaced", 12'h098, 32'h0000_000F);
    rd_chk("R7 hi kept", 12'h09C, 32'h0007_FFFF);
    wr(12'h098, 32'h0);
    wr(12'h09C, 32'h0);
    rd_chk("R7 hi zero", 12'h09C, 32'h0);
  endtask

  task automatic t_event;
    wr(12'h0D0, 32'h0);
    rd_chk("R8 lo ignored", 12'h0D0, 32'hFFF8_FFFF);
    wr(12'h0D4, 32'hFFFF_FFFF);
    rd_chk("R8 hi only 18:15", 12'h0D4, 32'h0007_DF07);
    @(negedge clk);
    chk("R8 cfg src48", {31'b0, cfg_event[48]}, 1);
    wr(12'h0D4, 32'h0);
    rd_chk("R8 fixed bits kept", 12'h0D4, 32'h0000_5F07);
    @(negedge clk);
    chk("R8 cfg src46", {31'b0, cfg_event[46]}, 1);
    chk("R3 cfg sense src16", {31'b0, cfg_sense[16]}, 0);
    chk("R3 cfg dual src16", {31'b0, cfg_dual[16]}, 1);
  endtask

  task automatic t_readonly;
    wr(12'h0A0, 32'hFFFF_FFFF);
    wr(12'h0A4, 32'hFFFF_FFFF);
    for (int k = 0; k < 7; k++) begin
      logic [11:0] a;
      case (k)
        0: a = 12'h080; 1: a = 12'h088; 2: a = 12'h090; 3: a = 12'h0B0;
        4: a = 12'h0C0; 5: a = 12'h0C8; default: a = 12'h0E0;
      endcase
      wr(a, 32'hFFFF_FFFF);
      wr(a + 12'h4, 32'hFFFF_FFFF);
    end
    idle(1);
    chk("R9 no irq from sw", {31'b0, irq}, 0);
    rd_chk("R9 raw untouched", 12'h090, 32'h0);
    rd_chk("R9 sense kept", 12'h0C0, 32'hFFF8_FFFF);
    rd_chk("R9 sense hi kept", 12'h0C4, 32'h0000_1F07);
    rd_chk("R9 dual kept", 12'h0C8, 32'h0007_0000);
    rd_chk("R9 en clr reads 0", 12'h0A8, 32'h0);
    rd_chk("R9 en clr hi 0", 12'h0AC, 32'h0);
    rd_chk("R9 sw set 0", 12'h0B0, 32'h0);
    rd_chk("R9 sw clr 0", 12'h0B8, 32'h0);
    rd_chk("R9 edge clr 0", 12'h0D8, 32'h0);
    rd_chk("R9 unmapped E8", 12'h0E8, 32'h0);
    rd_chk("R9 unmapped FFC", 12'hFFC, 32'h0);
    wr(12'h0A8, 32'hFFFF_FFFF);
    wr(12'h0AC, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_window();
    t_enable();
    t_level_route();
    t_edge();
    t_set_wins();
    t_select();
    t_event();
    t_readonly();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule